// File: doc/BRIEF.md
# Legacy Backplane Write-Strobe Shaper

This block sits between a fast processor's native bus control outputs and a slow 8-bit backplane. It regenerates the backplane write strobe, I/O request and memory request from the processor's strobes and two chip selects. Every output is registered on the processor clock and is active low.

For a write into the slow I/O window, the backplane write strobe is released early, a configured number of cycles before the processor lets go of its own strobe. The backplane I/O request is released on the same edge. Address and data remain driven by the processor after the release, so every backplane device gets extra hold time.

Memory writes, I/O reads and I/O writes outside the slow window are passed through with one register of delay. The backplane memory request comes from the memory chip select, not from the processor's native memory request.

Top module: `wr_strobe_adapter`

## Requirements
- R1: `bus_wr_n` goes low after the first clock edge that samples `cpu_wr_n` low, for memory writes and for I/O writes alike.
- R2: A shaped I/O write is one that begins with `cpu_iorq_n` and `io_cs_n` both low. Let L be `strobe_len`, the number of edges at which `cpu_wr_n` is sampled low, and C be `hold_cut`. For a shaped write, `bus_wr_n` stays low for exactly max(1, L - C) cycles.
- R3: While `cpu_iorq_n` is high at an edge, `bus_wr_n` after that edge equals `cpu_wr_n` sampled at that edge, so memory writes are unshortened.
- R4: On the edge where a shaped write releases `bus_wr_n` early, `bus_iorq_n` goes high too. It then stays high until `cpu_iorq_n` has been sampled high.
- R5: `bus_mreq_n` after each edge equals `mem_cs_n` sampled at that edge.
- R6: When C is greater than or equal to L, the backplane write strobe is still asserted for exactly one cycle.
- R7: An I/O read (`cpu_wr_n` high) passes `cpu_iorq_n` through to `bus_iorq_n` with one cycle of delay and no shortening.
- R8: An I/O write made with `io_cs_n` high is not shortened. `bus_wr_n` and `bus_iorq_n` follow the processor strobes with one cycle of delay.
- R9: A synchronous active-low reset (`rst_n` low at an edge) drives all three outputs high.
- R10: `bus_wr_n` and `bus_iorq_n` are never low after an edge at which the matching processor strobe was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_iorq_n | input | 1 | Processor I/O request, active low |
| mem_cs_n | input | 1 | Memory chip select for the backplane memory window, active low |
| io_cs_n | input | 1 | Chip select of the slow I/O window, active low |
| strobe_len | input | LEN_W | Length of the processor write strobe in clocks, fixed by its wait-state setting |
| hold_cut | input | CUT_W | Number of clocks by which an I/O write strobe is shortened |
| bus_wr_n | output | 1 | Backplane write strobe, active low |
| bus_iorq_n | output | 1 | Backplane I/O request, active low |
| bus_mreq_n | output | 1 | Backplane memory request, active low |

## Verification
The internal state of the block is small: a release counter, a flag marking an active shaped write, and a flag that keeps the I/O request high. If the counter loads the wrong value, `bus_wr_n` rises one or more cycles too early or too late within the same strobe. A stale hold flag shows up on the first cycle after the release, as a backplane I/O request that goes low again while the processor still holds its own. A shaped-write flag that is set wrongly shortens a memory or out-of-window write, and this shows on the very edge where the release would fall. The bench therefore compares all outputs on every cycle of each transaction, not only at its end.

// File: rtl/wr_strobe_pkg.sv
// Shared widths and helpers for the backplane strobe shaper.
// Assumes strobe lengths fit in STROBE_W bits and cut counts in CUT_DEF_W bits.
package wr_strobe_pkg;
    localparam int unsigned STROBE_W  = 4;
    localparam int unsigned CUT_DEF_W = 3;
endpackage

// File: rtl/wr_keep_calc.sv
// Computes the number of clocks minus one that a shaped write strobe stays
// low: max(1, len - cut) - 1. Purely combinational.
// Assumes len is the processor strobe length; a zero len is treated as one.
module wr_keep_calc #(
    parameter int unsigned LEN_W = 4,
    parameter int unsigned CUT_W = 3
) (
    input  logic [LEN_W-1:0] len,
    input  logic [CUT_W-1:0] cut,
    output logic [LEN_W-1:0] keep_m1
);
    localparam int unsigned MW = (LEN_W > CUT_W) ? LEN_W : CUT_W;

    logic [MW-1:0] len_x;
    logic [MW-1:0] cut_x;
    logic [MW-1:0] diff;

    // Widen both operands to a common width and clamp the difference.
    always_comb begin
        len_x = MW'(len);
        cut_x = MW'(cut);
        diff  = '0;
        if (len_x > cut_x + MW'(1)) begin
            diff = len_x - cut_x - MW'(1);
        end
        keep_m1 = diff[LEN_W-1:0];
    end
endmodule

// File: rtl/wr_release_timer.sv
// Down-counter that times the early release of a shaped write strobe.
// Loads on the start of a write and decrements while enabled until zero.
// Assumes load and tick are not both high in the same cycle.
module wr_release_timer #(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);
    logic [LEN_W-1:0] cnt;

    // Load on a new strobe, count down while the shaped write runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - LEN_W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/iorq_shaper.sv
// Registers the backplane I/O request. Once a shaped write releases early,
// the request is kept high until the processor drops its own request.
// Assumes release pulses for one cycle per write.
module iorq_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_iorq_n,
    input  logic release_now,
    output logic bus_iorq_n
);
    logic hold;
    logic hold_nxt;

    // Hold flag: set by an early release, cleared once the CPU request ends.
    always_comb begin
        hold_nxt = cpu_iorq_n ? 1'b0 : (hold | release_now);
    end

    // Register the hold flag and the gated request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold       <= 1'b0;
            bus_iorq_n <= 1'b1;
        end else begin
            hold       <= hold_nxt;
            bus_iorq_n <= cpu_iorq_n | hold_nxt;
        end
    end
endmodule

// File: rtl/wr_strobe_adapter.sv
// Top of the backplane strobe shaper. Registers WR, IORQ and MREQ toward the
// backplane. I/O writes in the slow window have WR and IORQ released
// hold_cut clocks early; all other cycles pass through one register stage.
// Assumes strobe_len and hold_cut are stable while a write strobe is low.
module wr_strobe_adapter
    import wr_strobe_pkg::*;
#(
    parameter int unsigned LEN_W = STROBE_W,
    parameter int unsigned CUT_W = CUT_DEF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_n,
    input  logic             cpu_iorq_n,
    input  logic             mem_cs_n,
    input  logic             io_cs_n,
    input  logic [LEN_W-1:0] strobe_len,
    input  logic [CUT_W-1:0] hold_cut,
    output logic             bus_wr_n,
    output logic             bus_iorq_n,
    output logic             bus_mreq_n
);
    logic             wr_q;
    logic             wr_fall;
    logic             io_sel;
    logic             shaped;
    logic             released;
    logic             release_now;
    logic             timer_zero;
    logic [LEN_W-1:0] keep_m1;

    wr_keep_calc #(.LEN_W(LEN_W), .CUT_W(CUT_W)) u_keep (
        .len     (strobe_len),
        .cut     (hold_cut),
        .keep_m1 (keep_m1)
    );

    // Edge detect and window decode for the current strobe.
    always_comb begin
        wr_fall     = wr_q && !cpu_wr_n;
        io_sel      = !cpu_iorq_n && !io_cs_n;
        release_now = shaped && !cpu_wr_n && !cpu_iorq_n && !wr_fall
                      && !released && timer_zero;
    end

    wr_release_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_fall),
        .load_val (keep_m1),
        .tick     (shaped && !cpu_wr_n && !wr_fall),
        .zero     (timer_zero)
    );

    // Track the previous write strobe for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
        end else begin
            wr_q <= cpu_wr_n;
        end
    end

    // Shape the backplane write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr_n <= 1'b1;
            shaped   <= 1'b0;
            released <= 1'b0;
        end else if (cpu_wr_n) begin
            bus_wr_n <= 1'b1;
            shaped   <= 1'b0;
            released <= 1'b0;
        end else if (wr_fall) begin
            bus_wr_n <= 1'b0;
            shaped   <= io_sel;
            released <= 1'b0;
        end else if (shaped && !cpu_iorq_n) begin
            if (released || release_now) begin
                bus_wr_n <= 1'b1;
                released <= 1'b1;
            end else begin
                bus_wr_n <= 1'b0;
            end
        end else begin
            bus_wr_n <= 1'b0;
            shaped   <= 1'b0;
        end
    end

    iorq_shaper u_iorq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_iorq_n  (cpu_iorq_n),
        .release_now (release_now),
        .bus_iorq_n  (bus_iorq_n)
    );

    // Backplane memory request comes from the memory chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_mreq_n <= 1'b1;
        end else begin
            bus_mreq_n <= mem_cs_n;
        end
    end
endmodule

// File: rtl/wr_strobe_adapter_chk.sv
// Temporal checks on the strobe shaper's ports, attached by bind.
module wr_strobe_adapter_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_wr_n,
    input logic cpu_iorq_n,
    input logic mem_cs_n,
    input logic bus_wr_n,
    input logic bus_iorq_n,
    input logic bus_mreq_n
);
    p_wr_assert_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_wr_n) |=> !bus_wr_n);

    p_mem_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_iorq_n |=> (bus_wr_n == $past(cpu_wr_n)));

    p_iorq_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_wr_n) && !$past(cpu_wr_n) && !$past(cpu_iorq_n)) |-> bus_iorq_n);

    p_mreq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |=> bus_mreq_n);

    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (bus_wr_n && bus_iorq_n && bus_mreq_n));

    p_wr_needs_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_n |=> bus_wr_n);

    p_iorq_needs_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_iorq_n |=> bus_iorq_n);
endmodule

bind wr_strobe_adapter wr_strobe_adapter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr_n   (cpu_wr_n),
    .cpu_iorq_n (cpu_iorq_n),
    .mem_cs_n   (mem_cs_n),
    .bus_wr_n   (bus_wr_n),
    .bus_iorq_n (bus_iorq_n),
    .bus_mreq_n (bus_mreq_n)
);

// File: tb/wr_strobe_adapter_bench.sv
module wr_strobe_adapter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_n = 1'b1;
    logic       cpu_iorq_n = 1'b1;
    logic       mem_cs_n = 1'b1;
    logic       io_cs_n = 1'b1;
    logic [3:0] strobe_len = 4'd4;
    logic [2:0] hold_cut = 3'd1;
    logic       bus_wr_n;
    logic       bus_iorq_n;
    logic       bus_mreq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wr_strobe_adapter u_wr_strobe_adapter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr_n   (cpu_wr_n),
        .cpu_iorq_n (cpu_iorq_n),
        .mem_cs_n   (mem_cs_n),
        .io_cs_n    (io_cs_n),
        .strobe_len (strobe_len),
        .hold_cut   (hold_cut),
        .bus_wr_n   (bus_wr_n),
        .bus_iorq_n (bus_iorq_n),
        .bus_mreq_n (bus_mreq_n)
    );

    task automatic expect_bit(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, check after the next rising edge.
    task automatic cycle(input logic wr, input logic iorq, input logic csm, input logic csi,
                         input logic e_wr, input logic e_iorq, input logic e_mreq,
                         input string tag);
        @(negedge clk);
        cpu_wr_n   = wr;
        cpu_iorq_n = iorq;
        mem_cs_n   = csm;
        io_cs_n    = csi;
        @(posedge clk);
        #1;
        expect_bit(bus_wr_n,   e_wr,   {tag, " bus_wr_n"});
        expect_bit(bus_iorq_n, e_iorq, {tag, " bus_iorq_n"});
        expect_bit(bus_mreq_n, e_mreq, {tag, " bus_mreq_n"});
    endtask

    // I/O write of len strobe cycles; iorq held tail cycles past the strobe.
    // in_window selects io_cs_n low (shaped, R2/R4/R6) or high (R8).
    task automatic io_write(input int len, input int cut, input int tail,
                            input bit in_window, input string tag);
        int keep;
        strobe_len = 4'(len);
        hold_cut   = 3'(cut);
        keep = (len > cut) ? len - cut : 1;
        for (int i = 0; i <= len + tail + 1; i++) begin
            logic wr, iorq, e_wr, e_iorq;
            wr   = (i >= 1 && i <= len) ? 1'b0 : 1'b1;
            iorq = (i <= len + tail) ? 1'b0 : 1'b1;
            if (in_window) begin
                e_wr   = (i >= 1 && i <= keep) ? 1'b0 : 1'b1;
                e_iorq = iorq | ((keep < len) && (i > keep));
            end else begin
                e_wr   = wr;
                e_iorq = iorq;
            end
            cycle(wr, iorq, 1'b1, in_window ? iorq : 1'b1, e_wr, e_iorq, 1'b1,
                  $sformatf("%s cyc%0d", tag, i));
        end
    endtask

    // Memory write: chip select around a strobe of len cycles (R3, R5, R1).
    task automatic mem_write(input int len, input int cut);
        strobe_len = 4'(len);
        hold_cut   = 3'(cut);
        for (int i = 0; i <= len + 2; i++) begin
            logic wr, csm;
            wr  = (i >= 1 && i <= len) ? 1'b0 : 1'b1;
            csm = (i <= len + 1) ? 1'b0 : 1'b1;
            cycle(wr, 1'b1, csm, 1'b1, wr, 1'b1, csm,
                  $sformatf("R3 R5 R1 mem write cyc%0d", i));
        end
    endtask

    // I/O read in the slow window: IORQ passes through (R7, R10).
    task automatic io_read(input int len, input int cut);
        strobe_len = 4'(len);
        hold_cut   = 3'(cut);
        for (int i = 0; i <= len + 1; i++) begin
            logic iorq;
            iorq = (i <= len) ? 1'b0 : 1'b1;
            cycle(1'b1, iorq, 1'b1, iorq, 1'b1, iorq, 1'b1,
                  $sformatf("R7 R10 io read cyc%0d", i));
        end
    endtask

    // Reset behaviour (R9).
    task automatic reset_check();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        expect_bit(bus_wr_n,   1'b1, "R9 reset bus_wr_n");
        expect_bit(bus_iorq_n, 1'b1, "R9 reset bus_iorq_n");
        expect_bit(bus_mreq_n, 1'b1, "R9 reset bus_mreq_n");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        reset_check();
        io_write(4, 1, 1, 1'b1, "R1 R2 R4 io write L4 C1");
        io_write(5, 2, 0, 1'b1, "R2 R4 io write L5 C2");
        io_write(3, 0, 1, 1'b1, "R2 io write no cut");
        io_write(2, 2, 1, 1'b1, "R6 clamp C=L");
        io_write(2, 5, 0, 1'b1, "R6 clamp C>L");
        mem_write(4, 2);
        io_read(3, 2);
        io_write(3, 2, 1, 1'b0, "R8 out of window");
        io_write(6, 1, 2, 1'b1, "R2 R4 io write L6 C1");
        reset_check();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule